// File: doc/BRIEF.md
# SD Host Command Path

This block is the command side of an SD host controller. A write to the command word, with its 32-bit argument, starts a 48-bit frame on the CMD line. The frame carries, in order: a start bit (0), a host-direction bit (1), the 6-bit command index, the argument, a CRC7 over those first 40 bits, and an end bit (1). The block advances one bit for each `bitTick` pulse, which the clock generator outside the block supplies once per SD clock period. After the end bit it releases the line. If the command word asks for a response, the block then waits for the card's start bit and shifts in a 48-bit or 136-bit reply.

The received response is checked against two optional tests: its CRC7 and its echoed index. The block also detects a card that never answers. For commands with busy signalling it watches DAT0 until the card lets go. Two inhibit flags gate new commands: one covers the CMD line and one covers the data side. Results are reported in a write-1-to-clear status word, whose bit 15 summarises all error bits.

Top module: `sdcmd_engine`

## Requirements
- R1: An accepted command drives `cmdLineOe` high and presents frame bit 47 first, then one bit lower per `bitTick`, for 48 ticks. The frame is {0, 1, index[5:0], argument[31:0], CRC7, 1}, with CRC7 using polynomial x^7+x^3+1 from a zero seed over the first 40 bits. After the 48th tick the line is released (`cmdLineOe`=0, `cmdLineOut`=1).
- R2: `presState` bit 0 (CMD busy) rises on the clock edge that accepts a command. It stays set until the response ends or times out. For response type 00 it stays set until the 48th tick of the frame, where status bit 0 (command done) is also set.
- R3: The command word is decoded as follows: index in bits [13:8], data-present flag in bit 5, index-check enable in bit 4, CRC-check enable in bit 3, response kind in bits [1:0]. The response kinds are 00 none, 01 136-bit, 10 48-bit and 11 48-bit with busy. For a 48-bit response, `respWords[31:0]` takes response bits [39:8] and status bit 0 is set.
- R4: For a 136-bit response, `respWords[119:0]` takes response bits [127:8] without the CRC, `respWords[127:120]` reads 0, and status bit 0 is set.
- R5: If no start bit (CMD low) is sampled within 64 ticks after the end bit, status bits 16 and 15 are set on the 64th tick and CMD busy clears. A start bit sampled on the 64th tick is still accepted.
- R6: With CRC check enabled, a received CRC7 that does not match sets status bits 17 and 15. For 48-bit responses the CRC covers bits [47:8]; for 136-bit responses it covers bits [127:8]. With the check disabled, no CRC error is raised.
- R7: With index check enabled, a 48-bit response whose bits [45:40] differ from the command index sets status bits 19 and 15. Index check has no effect on 136-bit responses or when disabled.
- R8: A type-11 command sets `presState` bit 1 (DAT busy) on acceptance. After a clean response, DAT busy clears on the first tick at which DAT0 is sampled high, and status bit 1 (transfer done) is set.
- R9: A command write is ignored while CMD busy is set. A write is also ignored while DAT busy is set if it has type 11 or the data-present flag set. Other commands are accepted while DAT busy is set.
- R10: Status bits 0, 1, 16, 17 and 19 clear only when `stsClr` is high with a 1 in the same bit of `stsClrMask`. Bit 15 reads as the OR of bits 16, 17 and 19.
- R11: `presState[23:20]` always reflects `datIn[3:0]`. The unused bits of `presState` read 0.
- R12: After reset, both busy flags, all status bits and `respWords` are 0, and the CMD line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| bitTick | input | 1 | One pulse per SD clock period |
| cmdWrite | input | 1 | Command word write strobe |
| cmdWord | input | 16 | Command word (index, flags, response kind) |
| cmdArg | input | 32 | Command argument |
| stsClr | input | 1 | Status write-1-to-clear strobe |
| stsClrMask | input | 32 | Bits to clear in the status word |
| cmdLineIn | input | 1 | Sampled CMD line |
| cmdLineOut | output | 1 | CMD line output value |
| cmdLineOe | output | 1 | CMD line output enable |
| datIn | input | 4 | Sampled DAT[3:0] levels |
| presState | output | 32 | Present state: CMD busy, DAT busy, DAT levels |
| irqStatus | output | 32 | Normal and error status bits |
| respWords | output | 128 | Captured response |

## Verification
The bench sweeps all 64 command indices through the transmitter against a CRC7 it computes itself. A wrong polynomial, a wrong bit order or an off-by-one in the CRC phase would corrupt at least one of these frames. Timeout is probed from both sides of the limit: a start bit on the 64th idle tick must be accepted, and a 64th high tick must raise the timeout. An off-by-one counter would get one of these two cases wrong. Long responses are sent with the index check enabled and reserved bits of all ones, so a design that applies the index check to 136-bit replies raises a false error. The busy case launches commands while DAT0 is held low: a design that gates on the wrong inhibit flag either accepts a second busy command or refuses a plain one.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int CMD_BITS   = 48;
  localparam int LONG_BITS  = 136;
  localparam int CRC_COVER  = 40;
  localparam int CRC_W      = 7;
  localparam int LONG_SKIP  = 8;
  localparam int LONG_KEEP  = LONG_BITS - 16;

  typedef enum logic [1:0] {
    RT_NONE  = 2'b00,
    RT_LONG  = 2'b01,
    RT_SHORT = 2'b10,
    RT_BUSY  = 2'b11
  } respKind_e;

  typedef enum logic [1:0] {
    DRV_TX  = 2'b00,
    DRV_CRC = 2'b01,
    DRV_END = 2'b10
  } drvSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_CHECK
  } cmdState_e;

  typedef struct packed {
    logic    loadTx;
    logic    txAdv;
    logic    crcOut;
    logic    crcClr;
    logic    rxClr;
    logic    rxAdv;
    logic    rxCrcEn;
    logic    cap48;
    logic    cap136;
    drvSel_e drvSel;
  } dpStrobe_t;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
  parameter int                 WIDTH = 7,
  parameter logic [WIDTH-1:0]   POLY  = 7'h09
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             updEn,
  input  logic             updBit,
  input  logic             shiftEn,
  output logic [WIDTH-1:0] crcVal
);
  logic fb;
  assign fb = updBit ^ crcVal[WIDTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        crcVal <= '0;
    else if (clr)     crcVal <= '0;
    else if (updEn)   crcVal <= {crcVal[WIDTH-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (shiftEn) crcVal <= {crcVal[WIDTH-2:0], 1'b0};
  end
endmodule

// File: rtl/sdcmd_datapath.sv
module sdcmd_datapath
  import sdcmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int RESP_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [IDX_W-1:0]  idxIn,
  input  logic [ARG_W-1:0]  argIn,
  input  logic              cmdLineIn,
  output logic              cmdLineOut,
  output logic              crcOk,
  output logic [IDX_W-1:0]  rxIndex,
  output logic [RESP_W-1:0] respWords
);
  localparam int TX_W    = 2 + IDX_W + ARG_W;
  localparam int RX_W    = LONG_BITS;
  localparam int IDX_LSB = ARG_W + 8;

  logic [TX_W-1:0]  txShift;
  logic [RX_W-1:0]  rxShift;
  logic [CRC_W-1:0] crcVal;
  logic             crcUpd;
  logic             crcBit;

  assign crcUpd = stb.txAdv | (stb.rxAdv & stb.rxCrcEn);
  assign crcBit = stb.txAdv ? txShift[TX_W-1] : cmdLineIn;

  sdcmd_crc7 #(.WIDTH(CRC_W), .POLY(7'h09)) crc_i (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (stb.loadTx | stb.crcClr),
    .updEn   (crcUpd),
    .updBit  (crcBit),
    .shiftEn (stb.crcOut),
    .crcVal  (crcVal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txShift <= '0;
    else if (stb.loadTx)    txShift <= {2'b01, idxIn, argIn};
    else if (stb.txAdv)     txShift <= {txShift[TX_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxShift <= '0;
    else if (stb.rxClr)     rxShift <= '0;
    else if (stb.rxAdv)     rxShift <= {rxShift[RX_W-2:0], cmdLineIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              respWords <= '0;
    else if (stb.cap136)    respWords <= {{(RESP_W-LONG_KEEP){1'b0}}, rxShift[LONG_KEEP+7:8]};
    else if (stb.cap48)     respWords[ARG_W-1:0] <= rxShift[ARG_W+7:8];
  end

  always_comb begin
    unique case (stb.drvSel)
      DRV_TX:  cmdLineOut = txShift[TX_W-1];
      DRV_CRC: cmdLineOut = crcVal[CRC_W-1];
      default: cmdLineOut = 1'b1;
    endcase
  end

  assign crcOk   = (crcVal == rxShift[CRC_W:1]);
  assign rxIndex = rxShift[IDX_LSB+IDX_W-1:IDX_LSB];

  logic unusedRxBits;
  assign unusedRxBits = ^{rxShift[RX_W-1:LONG_KEEP+8], rxShift[0]};
endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int TO_TICKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             cmdWrite,
  input  logic [15:0]      cmdWord,
  input  logic             cmdLineIn,
  input  logic             dat0,
  input  logic             stsClr,
  input  logic [31:0]      stsClrMask,
  input  logic             crcOk,
  input  logic [IDX_W-1:0] rxIndex,
  output dpStrobe_t        stb,
  output logic             cmdInhibit,
  output logic             datInhibit,
  output logic             cmdLineOe,
  output logic [31:0]      irqStatus
);
  localparam int CNT_W = $clog2(LONG_BITS);
  localparam int TO_W  = $clog2(TO_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_TX    = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] TX_CRC_AT  = CNT_W'(CRC_COVER);
  localparam logic [CNT_W-1:0] TX_END_AT  = CNT_W'(CRC_COVER + CRC_W);
  localparam logic [CNT_W-1:0] LONG_LO    = CNT_W'(LONG_SKIP);
  localparam logic [CNT_W-1:0] LONG_HI    = CNT_W'(LONG_SKIP + LONG_KEEP);
  localparam logic [TO_W-1:0]  TO_LAST    = TO_W'(TO_TICKS - 1);

  cmdState_e        state;
  logic [CNT_W-1:0] bitCnt;
  logic [TO_W-1:0]  waitCnt;
  logic [IDX_W-1:0] curIdx;
  respKind_e        curKind;
  logic             curIdxChk, curCrcChk;
  logic             busyWatch;

  // status: 0 done, 1 xfer done, 2 timeout, 3 crc error, 4 index error
  logic [4:0] sts, stsSet, stsClrVec;

  respKind_e newKind;
  logic accept, isShort, isBusy, sendEnd, startSeen, timeoutNow;
  logic crcBad, idxBad, busyEnd;
  logic [CNT_W-1:0] lastRx;

  assign newKind    = respKind_e'(cmdWord[1:0]);
  assign accept     = cmdWrite && !cmdInhibit &&
                      !(datInhibit && (newKind == RT_BUSY || cmdWord[5]));
  assign isShort    = (curKind == RT_SHORT) || (curKind == RT_BUSY);
  assign isBusy     = (curKind == RT_BUSY);
  assign lastRx     = isShort ? LAST_SHORT : LAST_LONG;
  assign sendEnd    = (state == ST_SEND) && bitTick && (bitCnt == LAST_TX);
  assign startSeen  = (state == ST_WAIT) && bitTick && !cmdLineIn;
  assign timeoutNow = (state == ST_WAIT) && bitTick && cmdLineIn && (waitCnt == TO_LAST);
  assign crcBad     = curCrcChk && !crcOk;
  assign idxBad     = curIdxChk && isShort && (rxIndex != curIdx);
  assign busyEnd    = busyWatch && bitTick && dat0;

  always_comb begin
    stb        = '0;
    stb.drvSel = DRV_END;
    cmdLineOe  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stb.loadTx = accept;
        stb.rxClr  = accept;
      end
      ST_SEND: begin
        cmdLineOe = 1'b1;
        if (bitCnt < TX_CRC_AT)      stb.drvSel = DRV_TX;
        else if (bitCnt < TX_END_AT) stb.drvSel = DRV_CRC;
        if (bitTick) begin
          stb.txAdv  = (bitCnt < TX_CRC_AT);
          stb.crcOut = (bitCnt >= TX_CRC_AT) && (bitCnt < TX_END_AT);
          stb.crcClr = (bitCnt == LAST_TX);
        end
      end
      ST_WAIT: begin
        stb.rxAdv   = startSeen;
        stb.rxCrcEn = startSeen && isShort;
      end
      ST_RECV: begin
        stb.rxAdv   = bitTick;
        stb.rxCrcEn = bitTick && (isShort ? (bitCnt < TX_CRC_AT)
                                          : (bitCnt >= LONG_LO && bitCnt < LONG_HI));
      end
      ST_CHECK: begin
        stb.cap48  = isShort;
        stb.cap136 = !isShort;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      waitCnt    <= '0;
      curIdx     <= '0;
      curKind    <= RT_NONE;
      curIdxChk  <= 1'b0;
      curCrcChk  <= 1'b0;
      cmdInhibit <= 1'b0;
      datInhibit <= 1'b0;
      busyWatch  <= 1'b0;
    end else begin
      if (busyEnd) begin
        busyWatch  <= 1'b0;
        datInhibit <= 1'b0;
      end
      unique case (state)
        ST_IDLE: if (accept) begin
          state      <= ST_SEND;
          bitCnt     <= '0;
          curIdx     <= cmdWord[13:8];
          curKind    <= newKind;
          curIdxChk  <= cmdWord[4];
          curCrcChk  <= cmdWord[3];
          cmdInhibit <= 1'b1;
          if (newKind == RT_BUSY) datInhibit <= 1'b1;
        end
        ST_SEND: if (bitTick) begin
          if (bitCnt == LAST_TX) begin
            if (curKind == RT_NONE) begin
              state      <= ST_IDLE;
              cmdInhibit <= 1'b0;
            end else begin
              state   <= ST_WAIT;
              waitCnt <= '0;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (startSeen) begin
            state  <= ST_RECV;
            bitCnt <= CNT_W'(1);
          end else if (timeoutNow) begin
            state      <= ST_IDLE;
            cmdInhibit <= 1'b0;
            if (isBusy) datInhibit <= 1'b0;
          end else if (bitTick) begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RECV: if (bitTick) begin
          if (bitCnt == lastRx) state <= ST_CHECK;
          else                  bitCnt <= bitCnt + 1'b1;
        end
        ST_CHECK: begin
          state      <= ST_IDLE;
          cmdInhibit <= 1'b0;
          if (isBusy) begin
            if (crcBad || idxBad) datInhibit <= 1'b0;
            else                  busyWatch  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stsSet[0] = (sendEnd && curKind == RT_NONE) || (state == ST_CHECK);
    stsSet[1] = busyEnd;
    stsSet[2] = timeoutNow;
    stsSet[3] = (state == ST_CHECK) && crcBad;
    stsSet[4] = (state == ST_CHECK) && idxBad;
    stsClrVec = stsClr ? {stsClrMask[19], stsClrMask[17], stsClrMask[16],
                          stsClrMask[1], stsClrMask[0]} : 5'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sts <= '0;
    else       sts <= stsSet | (sts & ~stsClrVec);
  end

  assign irqStatus = {12'b0, sts[4], 1'b0, sts[3], sts[2], |sts[4:2],
                      13'b0, sts[1], sts[0]};

  logic unusedInBits;
  assign unusedInBits = ^{cmdWord[15:14], cmdWord[7:6], cmdWord[2],
                          stsClrMask[31:20], stsClrMask[18], stsClrMask[15:2]};
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TO_TICKS = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitTick,
  input  logic         cmdWrite,
  input  logic [15:0]  cmdWord,
  input  logic [31:0]  cmdArg,
  input  logic         stsClr,
  input  logic [31:0]  stsClrMask,
  input  logic         cmdLineIn,
  output logic         cmdLineOut,
  output logic         cmdLineOe,
  input  logic [3:0]   datIn,
  output logic [31:0]  presState,
  output logic [31:0]  irqStatus,
  output logic [127:0] respWords
);
  localparam int IDX_W = 6;

  dpStrobe_t        stb;
  logic             crcOk;
  logic [IDX_W-1:0] rxIndex;
  logic             cmdInhibit, datInhibit;

  sdcmd_ctrl #(.IDX_W(IDX_W), .TO_TICKS(TO_TICKS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .cmdWrite   (cmdWrite),
    .cmdWord    (cmdWord),
    .cmdLineIn  (cmdLineIn),
    .dat0       (datIn[0]),
    .stsClr     (stsClr),
    .stsClrMask (stsClrMask),
    .crcOk      (crcOk),
    .rxIndex    (rxIndex),
    .stb        (stb),
    .cmdInhibit (cmdInhibit),
    .datInhibit (datInhibit),
    .cmdLineOe  (cmdLineOe),
    .irqStatus  (irqStatus)
  );

  sdcmd_datapath #(.IDX_W(IDX_W), .ARG_W(32), .RESP_W(128)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .idxIn      (cmdWord[13:8]),
    .argIn      (cmdArg),
    .cmdLineIn  (cmdLineIn),
    .cmdLineOut (cmdLineOut),
    .crcOk      (crcOk),
    .rxIndex    (rxIndex),
    .respWords  (respWords)
  );

  assign presState = {8'b0, datIn, 18'b0, datInhibit, cmdInhibit};
endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWrite,
  input logic        cmdLineOe,
  input logic [31:0] presState,
  input logic [31:0] irqStatus
);
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdLineOe |-> presState[0]); // R2

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(presState[0]) |-> $past(cmdWrite)); // R9

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[0]) |-> !presState[0]); // R2

  AST_TIMEOUT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[16]) |-> $fell(presState[0])); // R5

  AST_XFER_WITH_DAT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[1]) |-> $fell(presState[1])); // R8
endmodule

bind sdcmd_engine sdcmd_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cmdWrite  (cmdWrite),
  .cmdLineOe (cmdLineOe),
  .presState (presState),
  .irqStatus (irqStatus)
);

// File: tb/sdcmd_engine_tb_top.sv
module sdcmd_engine_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bitTick = 1'b0;
  logic         cmdWrite = 1'b0;
  logic [15:0]  cmdWord = '0;
  logic [31:0]  cmdArg = '0;
  logic         stsClr = 1'b0;
  logic [31:0]  stsClrMask = '0;
  logic         cmdLineIn = 1'b1;
  logic         cmdLineOut, cmdLineOe;
  logic [3:0]   datIn = 4'hF;
  logic [31:0]  presState, irqStatus;
  logic [127:0] respWords;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sdcmd_engine dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cmdWrite(cmdWrite),
    .cmdWord(cmdWord), .cmdArg(cmdArg), .stsClr(stsClr), .stsClrMask(stsClrMask),
    .cmdLineIn(cmdLineIn), .cmdLineOut(cmdLineOut), .cmdLineOe(cmdLineOe),
    .datIn(datIn), .presState(presState), .irqStatus(irqStatus), .respWords(respWords)
  );

  localparam logic [31:0] DONE = 32'h1, XFER = 32'h2, ANYE = 32'h8000,
                          TOE = 32'h10000, CRCE = 32'h20000, IDXE = 32'h80000;

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7f(input logic [135:0] v, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] cmdFrame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, crc7f({96'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [15:0] mkWord(input logic [5:0] idx, input logic dp,
                                         input logic ic, input logic cc, input logic [1:0] kind);
    return {2'b00, idx, 2'b00, dp, ic, cc, 1'b0, kind};
  endfunction

  function automatic logic [135:0] shortResp(input logic [5:0] idx, input logic [31:0] pl,
                                             input logic [6:0] flip);
    logic [39:0] h;
    h = {2'b00, idx, pl};
    return {88'b0, h, crc7f({96'b0, h}, 40) ^ flip, 1'b1};
  endfunction

  function automatic logic [135:0] longResp(input logic [119:0] body);
    return {2'b00, 6'h3F, body, crc7f({16'b0, body}, 120), 1'b1};
  endfunction

  task automatic tick();
    bitTick = 1'b1;
    @(negedge clk); bitTick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic launch(input logic [15:0] w, input logic [31:0] a);
    cmdWord = w; cmdArg = a; cmdWrite = 1'b1;
    @(negedge clk); cmdWrite = 1'b0;
  endtask

  task automatic clearSts(input logic [31:0] m);
    stsClrMask = m; stsClr = 1'b1;
    @(negedge clk); stsClr = 1'b0;
  endtask

  task automatic sendCheck(input logic [47:0] fr, input int intAt,
                           input logic [15:0] alt, input string req);
    int errs = 0;
    for (int k = 0; k < 48; k++) begin
      if (k == intAt) begin
        cmdWord = alt; cmdArg = 32'hFFFF_FFFF; cmdWrite = 1'b1;
        @(negedge clk); cmdWrite = 1'b0;
      end
      if (!cmdLineOe || cmdLineOut !== fr[47-k]) errs++;
      tick();
    end
    check(errs == 0, req, errs, 0);
    check(!cmdLineOe && cmdLineOut, {req, " R1 release"}, {cmdLineOe, cmdLineOut}, 2'b01);
  endtask

  task automatic respond(input logic [135:0] fr, input int len, input int pre);
    for (int i = 0; i < pre; i++) begin cmdLineIn = 1'b1; tick(); end
    for (int i = len - 1; i >= 0; i--) begin cmdLineIn = fr[i]; tick(); end
    cmdLineIn = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [135:0] fr;
    logic [119:0] body;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(presState[1:0] == 2'b00 && irqStatus == 0 && respWords == 0 && !cmdLineOe && cmdLineOut,
          "R12 reset", {presState, irqStatus}, 0);

    // R1 R2 sweep every index with no-response commands
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      a = (32'(i) * 32'h0405_0607) ^ 32'hA5C3_0F1E;
      launch(mkWord(6'(i), 1'b0, 1'b0, 1'b0, 2'b00), a);
      check(presState[0] == 1'b1, "R2 busy on launch", presState[0], 1);
      sendCheck(cmdFrame(6'(i), a), -1, 16'h0, "R1 frame");
      check(irqStatus == DONE && presState[0] == 1'b0, "R2 no-resp done", irqStatus, DONE);
      clearSts(32'h1);
    end

    // R3 48-bit response
    launch(mkWord(6'd17, 1'b0, 1'b1, 1'b1, 2'b10), 32'h1234_5678);
    sendCheck(cmdFrame(6'd17, 32'h1234_5678), -1, 16'h0, "R1 frame short");
    check(presState[0] == 1'b1, "R2 busy while waiting", presState[0], 1);
    respond(shortResp(6'd17, 32'hCAFE_F00D, 7'h0), 48, 3);
    check(respWords[31:0] == 32'hCAFE_F00D, "R3 short payload", respWords[31:0], 32'hCAFE_F00D);
    check(irqStatus == DONE && presState[0] == 1'b0, "R3 short done", irqStatus, DONE);
    clearSts(32'hFFFF_FFFF);

    // R4 136-bit response, index check enabled has no effect (R7)
    body = {32'h0123_4567, 32'h89AB_CDEF, 32'hDEAD_BEEF, 24'h5A_A55A};
    launch(mkWord(6'd2, 1'b0, 1'b1, 1'b1, 2'b01), 32'h0);
    sendCheck(cmdFrame(6'd2, 32'h0), -1, 16'h0, "R1 frame long");
    respond(longResp(body), 136, 0);
    check(respWords == {8'h00, body}, "R4 long payload", respWords, {8'h00, body});
    check(irqStatus == DONE, "R7 no index check on long, R6 crc ok", irqStatus, DONE);
    clearSts(32'hFFFF_FFFF);

    // R6 CRC error with check on
    launch(mkWord(6'd13, 1'b0, 1'b0, 1'b1, 2'b10), 32'h55);
    sendCheck(cmdFrame(6'd13, 32'h55), -1, 16'h0, "R1 frame");
    respond(shortResp(6'd13, 32'h0BAD_0BAD, 7'h04), 48, 1);
    check(irqStatus == (DONE | ANYE | CRCE), "R6 crc error", irqStatus, DONE | ANYE | CRCE);
    // R10 clear only the crc bit
    clearSts(CRCE);
    check(irqStatus == DONE, "R10 partial clear", irqStatus, DONE);
    clearSts(DONE);
    check(irqStatus == 0, "R10 full clear", irqStatus, 0);

    // R6 CRC error with check off
    launch(mkWord(6'd13, 1'b0, 1'b0, 1'b0, 2'b10), 32'h56);
    sendCheck(cmdFrame(6'd13, 32'h56), -1, 16'h0, "R1 frame");
    respond(shortResp(6'd13, 32'h1, 7'h40), 48, 0);
    check(irqStatus == DONE, "R6 crc check off", irqStatus, DONE);
    clearSts(32'hFFFF_FFFF);

    // R6 long response with bad CRC
    launch(mkWord(6'd9, 1'b0, 1'b0, 1'b1, 2'b01), 32'h9);
    sendCheck(cmdFrame(6'd9, 32'h9), -1, 16'h0, "R1 frame");
    fr = longResp(body); fr[1] = ~fr[1];
    respond(fr, 136, 2);
    check(irqStatus == (DONE | ANYE | CRCE), "R6 long crc error", irqStatus, DONE | ANYE | CRCE);
    clearSts(32'hFFFF_FFFF);

    // R7 index mismatch on/off
    launch(mkWord(6'd40, 1'b0, 1'b1, 1'b1, 2'b10), 32'h40);
    sendCheck(cmdFrame(6'd40, 32'h40), -1, 16'h0, "R1 frame");
    respond(shortResp(6'd41, 32'h7, 7'h0), 48, 0);
    check(irqStatus == (DONE | ANYE | IDXE), "R7 index error", irqStatus, DONE | ANYE | IDXE);
    clearSts(32'hFFFF_FFFF);
    launch(mkWord(6'd40, 1'b0, 1'b0, 1'b1, 2'b10), 32'h41);
    sendCheck(cmdFrame(6'd40, 32'h41), -1, 16'h0, "R1 frame");
    respond(shortResp(6'd41, 32'h7, 7'h0), 48, 0);
    check(irqStatus == DONE, "R7 index check off", irqStatus, DONE);
    clearSts(32'hFFFF_FFFF);

    // R5 start bit on the 64th tick is accepted
    launch(mkWord(6'd3, 1'b0, 1'b0, 1'b1, 2'b10), 32'h3);
    sendCheck(cmdFrame(6'd3, 32'h3), -1, 16'h0, "R1 frame");
    respond(shortResp(6'd3, 32'h3333, 7'h0), 48, 63);
    check(irqStatus == DONE, "R5 late start accepted", irqStatus, DONE);
    clearSts(32'hFFFF_FFFF);

    // R5 timeout after 64 high ticks
    launch(mkWord(6'd8, 1'b0, 1'b0, 1'b0, 2'b10), 32'h8);
    sendCheck(cmdFrame(6'd8, 32'h8), -1, 16'h0, "R1 frame");
    for (int i = 0; i < 63; i++) tick();
    check(irqStatus == 0 && presState[0], "R5 no early timeout", irqStatus, 0);
    tick();
    check(irqStatus == (TOE | ANYE) && !presState[0], "R5 timeout", irqStatus, TOE | ANYE);
    clearSts(TOE);
    check(irqStatus == 0, "R10 clear timeout drops summary", irqStatus, 0);

    // R9 write during a command is ignored
    launch(mkWord(6'd21, 1'b0, 1'b0, 1'b0, 2'b00), 32'h2121_2121);
    sendCheck(cmdFrame(6'd21, 32'h2121_2121), 20, mkWord(6'd63, 1'b0, 1'b0, 1'b0, 2'b00),
              "R9 write ignored while cmd busy");
    check(irqStatus == DONE && !presState[0], "R9 single completion", irqStatus, DONE);
    clearSts(32'hFFFF_FFFF);

    // R8 busy response with DAT0 low
    datIn = 4'b1110;
    launch(mkWord(6'd7, 1'b0, 1'b1, 1'b1, 2'b11), 32'h77);
    check(presState[1:0] == 2'b11, "R8 both busy on launch", presState[1:0], 2'b11);
    sendCheck(cmdFrame(6'd7, 32'h77), -1, 16'h0, "R1 frame busy");
    respond(shortResp(6'd7, 32'h900, 7'h0), 48, 2);
    check(presState[1:0] == 2'b10 && irqStatus == DONE, "R8 dat busy held", presState[1:0], 2'b10);
    for (int i = 0; i < 3; i++) tick();
    check(presState[1] == 1'b1 && irqStatus[1] == 1'b0, "R8 still busy while dat0 low",
          presState[1:0], 2'b10);
    launch(mkWord(6'd9, 1'b0, 1'b0, 1'b0, 2'b11), 32'h9);
    @(negedge clk);
    check(!presState[0] && !cmdLineOe, "R9 busy-type refused", presState[0], 0);
    launch(mkWord(6'd24, 1'b1, 1'b0, 1'b0, 2'b10), 32'h9);
    @(negedge clk);
    check(!presState[0] && !cmdLineOe, "R9 data-present refused", presState[0], 0);
    launch(mkWord(6'd5, 1'b0, 1'b0, 1'b0, 2'b00), 32'h5555);
    check(presState[0] == 1'b1, "R9 plain cmd accepted during dat busy", presState[0], 1);
    sendCheck(cmdFrame(6'd5, 32'h5555), -1, 16'h0, "R9 plain frame");
    datIn = 4'b1111;
    tick();
    check(presState[1:0] == 2'b00 && irqStatus == (DONE | XFER), "R8 busy release",
          irqStatus, DONE | XFER);
    clearSts(XFER);
    check(irqStatus == DONE, "R10 clear xfer only", irqStatus, DONE);
    clearSts(DONE);

    // R11 DAT levels in present state
    for (int v = 0; v < 16; v++) begin
      datIn = 4'(v);
      @(negedge clk);
      check(presState[23:20] == 4'(v) && presState[31:24] == 0 && presState[19:2] == 0,
            "R11 dat levels", presState, 32'(v) << 20);
    end
    datIn = 4'hF;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule